// File: doc/BRIEF.md
# Sticky Serial Set/Clear Pattern Detector

This block watches a one-bit serial stream, taking one bit on every rising clock edge. The pair "0 followed by 1" on consecutive bits raises the output `z`. The output then stays high through any run of ones and through single zeros. Only the pair "0 followed by 0" drops it again. This makes it a set/clear flag that the stream itself drives. It is not a pulse on each match.

A parameter picks one of two forms. In the Mealy form (`MOORE_FORM = 0`) there are three states, and `z` is a combinational function of the state and the present bit. That means `z` can rise in the same cycle as the completing `1`. In the Moore form (`MOORE_FORM = 1`) there are four states, and `z` comes from the state alone. It therefore changes only after a clock edge.

The state register is brought out on `stateOut` so that the encoding can be checked. Its encoding is A = 00 (idle), B = 01 (last bit was 0, flag low), C = 10 (flag high) and D = 11 (Moore only: flag high, last bit was 0).

Top module: `seqdet_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is A (`stateOut` = 00), and `z` is 0 in state A for either value of `x`.
- R2: A `0` followed by a `1` on the next cycle, both after reset has been released, leaves the machine in state C (`stateOut` = 10) with `z` = 1, in both forms.
- R3: A `0` followed by a `0` leaves the machine in state B (`stateOut` = 01), in both forms. In the Moore form `z` is then 0.
- R4: In state C an input of `1` keeps the state at C, and `z` stays 1.
- R5: Moore form: from C a single `0` moves to D (`stateOut` = 11) with `z` still 1. From D a `1` returns to C and a `0` goes to B.
- R6: Mealy form: in state B, `z` equals the present `x` in the same cycle, and in state C, `z` is 1 for either input.
- R7: Moore form: `z` is 1 exactly in states C and D and does not follow `x` within a cycle.
- R8: Mealy form: `stateOut` only ever holds 00, 01 or 10, and every bit moves the state as R2 to R4 and R9 describe.
- R9: From A, a `1` keeps the state at A with `z` = 0.
- R10: With the same stream, the two forms diverge only in that after "0,1,0" the Mealy form sits in B while the Moore form sits in D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x | input | 1 | Serial data bit, one per clock |
| z | output | 1 | Sticky detect flag |
| stateOut | output | 2 | Present state code (A=00, B=01, C=10, D=11) |

## Verification
The pattern properties use the previous bit, so they assume that `x` holds one settled value around each rising edge and that the previous bit is known. The checker only trusts a bit that it captured after reset was released. The bench changes `x` only at the falling edge. It holds reset for several cycles before every stream, so no property ever looks back at a bit taken during reset. The same streams drive both forms side by side: every string up to six bits long, plus the directed streams.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int STATE_BITS = 2;

  typedef logic [STATE_BITS-1:0] state_t;

  localparam state_t ST_A = 2'b00;
  localparam state_t ST_B = 2'b01;
  localparam state_t ST_C = 2'b10;
  localparam state_t ST_D = 2'b11;

  // Strobes from control into the state datapath: per bit set and clear (JK style)
  typedef struct packed {
    logic [STATE_BITS-1:0] jSet;
    logic [STATE_BITS-1:0] kClr;
  } jkStrobe_t;

endpackage

// File: rtl/seqdet_ctrl.sv
module seqdet_ctrl
  import seqdet_pkg::*;
#(
  parameter bit MOORE_FORM = 1'b0
) (
  input  logic      x,
  input  state_t    curState,
  output jkStrobe_t strobe
);

  localparam int HI = 1;
  localparam int LO = 0;

  generate
    if (MOORE_FORM) begin : g_moore
      // Low bit records "last bit was zero"; high bit is the sticky flag.
      always_comb begin
        strobe = '0;
        strobe.jSet[LO] = ~x;
        strobe.kClr[LO] = x;
        strobe.jSet[HI] = x & curState[LO];
        strobe.kClr[HI] = ~x & curState[LO];
      end
    end else begin : g_mealy
      logic illegal;
      assign illegal = (curState == ST_D);
      always_comb begin
        strobe = '0;
        if (illegal) begin
          // unused code: clear both bits, landing in A
          strobe.kClr = '1;
        end else begin
          strobe.jSet[LO] = ~x;
          strobe.kClr[LO] = x;
          strobe.jSet[HI] = x & curState[LO];
          strobe.kClr[HI] = ~x;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/seqdet_datapath.sv
module seqdet_datapath
  import seqdet_pkg::*;
#(
  parameter bit MOORE_FORM = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      x,
  input  jkStrobe_t strobe,
  output state_t    curState,
  output logic      z
);

  state_t stateReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateReg <= ST_A;
    end else begin
      for (int i = 0; i < STATE_BITS; i++) begin
        stateReg[i] <= (strobe.jSet[i] & ~stateReg[i]) | (~strobe.kClr[i] & stateReg[i]);
      end
    end
  end

  assign curState = stateReg;

  generate
    if (MOORE_FORM) begin : g_mooreOut
      assign z = stateReg[1];
    end else begin : g_mealyOut
      assign z = stateReg[1] | (x & stateReg[0]);
    end
  endgenerate

endmodule

// File: rtl/seqdet_top.sv
module seqdet_top
  import seqdet_pkg::*;
#(
  parameter bit MOORE_FORM = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       x,
  output logic       z,
  output logic [1:0] stateOut
);

  jkStrobe_t strobe;
  state_t    curState;

  seqdet_ctrl #(.MOORE_FORM(MOORE_FORM)) ctrl (
    .x        (x),
    .curState (curState),
    .strobe   (strobe)
  );

  seqdet_datapath #(.MOORE_FORM(MOORE_FORM)) dp (
    .clk      (clk),
    .rst      (rst),
    .x        (x),
    .strobe   (strobe),
    .curState (curState),
    .z        (z)
  );

  assign stateOut = curState;

endmodule

// File: rtl/seqdet_check.sv
module seqdet_check #(
  parameter bit MOORE_FORM = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       x,
  input logic       z,
  input logic [1:0] stateOut
);

  logic prevX;
  logic prevValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevX     <= 1'b1;
      prevValid <= 1'b0;
    end else begin
      prevX     <= x;
      prevValid <= 1'b1;
    end
  end

  assert_reset_to_idle_R1: assert property (@(posedge clk) rst |=> (stateOut == 2'b00));

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 2'b00) |-> !z);

  assert_set_pair_R2: assert property (@(posedge clk) disable iff (rst)
    (prevValid && !prevX && x) |=> (stateOut == 2'b10));

  assert_clear_pair_R3: assert property (@(posedge clk) disable iff (rst)
    (prevValid && !prevX && !x) |=> (stateOut == 2'b01));

  assert_hold_high_R4: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 2'b10) |-> z);

  generate
    if (MOORE_FORM) begin : g_mooreChk
      assert_state_only_R7: assert property (@(posedge clk) disable iff (rst)
        (prevValid && $stable(stateOut)) |-> $stable(z));
      assert_single_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (stateOut == 2'b10 && !x) |=> (stateOut == 2'b11 && z));
    end else begin : g_mealyChk
      assert_legal_code_R8: assert property (@(posedge clk) disable iff (rst)
        stateOut != 2'b11);
      assert_follow_input_R6: assert property (@(posedge clk) disable iff (rst)
        (stateOut == 2'b01) |-> (z == x));
    end
  endgenerate

endmodule

bind seqdet_top seqdet_check #(.MOORE_FORM(MOORE_FORM)) chk (
  .clk      (clk),
  .rst      (rst),
  .x        (x),
  .z        (z),
  .stateOut (stateOut)
);

// File: tb/seqdet_top_test.sv
`timescale 1ns/1ps
module seqdet_top_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       x = 1'b0;
  logic       zMealy, zMoore;
  logic [1:0] stMealy, stMoore;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  bit mPrevZero;
  bit mHeld;

  always #4 clk = ~clk;

  seqdet_top #(.MOORE_FORM(1'b0)) uut (
    .clk(clk), .rst(rst), .x(x), .z(zMealy), .stateOut(stMealy)
  );

  seqdet_top #(.MOORE_FORM(1'b1)) uut2 (
    .clk(clk), .rst(rst), .x(x), .z(zMoore), .stateOut(stMoore)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    x = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mPrevZero = 0;
    mHeld = 0;
    #1;
    check("R1 mealy state", stMealy, 2'b00);
    check("R1 moore state", stMoore, 2'b00);
    check("R1 mealy z", {1'b0, zMealy}, 2'b00);
    check("R1 moore z", {1'b0, zMoore}, 2'b00);
  endtask

  task automatic step(input logic b, input string tag);
    bit newHeld;
    logic [1:0] expMealy, expMoore;
    @(negedge clk);
    x = b;
    #1;
    newHeld  = mPrevZero ? b : mHeld;
    expMealy = !b ? 2'b01 : (newHeld ? 2'b10 : 2'b00);
    expMoore = !b ? (newHeld ? 2'b11 : 2'b01) : (newHeld ? 2'b10 : 2'b00);
    check({tag, " R6 mealy z"}, {1'b0, zMealy}, {1'b0, newHeld});
    check({tag, " R7 moore z before edge"}, {1'b0, zMoore}, {1'b0, mHeld});
    @(posedge clk);
    #1;
    check({tag, " R8 mealy state"}, stMealy, expMealy);
    check({tag, " R5 moore state"}, stMoore, expMoore);
    check({tag, " R7 moore z"}, {1'b0, zMoore}, {1'b0, newHeld});
    mHeld = newHeld;
    mPrevZero = !b;
  endtask

  task automatic runStream(input logic [15:0] bits, input int len, input string tag);
    doReset();
    for (int i = len - 1; i >= 0; i--) step(bits[i], tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // directed streams
    runStream(16'b01, 2, "R2");
    check("R2 mealy set", stMealy, 2'b10);
    check("R2 moore set", {stMoore[1], zMoore}, 2'b11);
    runStream(16'b0101, 4, "R2");
    runStream(16'b0100, 4, "R3");
    check("R3 clear both", {stMealy, stMoore}, 4'b0101);
    check("R3 moore z low", {1'b0, zMoore}, 2'b00);
    runStream(16'b011100, 6, "R4");
    runStream(16'b0111, 4, "R4");
    check("R4 still set", {stMealy, zMealy, zMoore}, 4'b1011);
    runStream(16'b11, 2, "R9");
    check("R9 idle", {stMealy, stMoore}, 4'b0000);
    runStream(16'b010, 3, "R10");
    check("R10 mealy in B", stMealy, 2'b01);
    check("R10 moore in D", stMoore, 2'b11);
    runStream(16'b01001, 5, "R5");
    // near-exhaustive sweep over all strings up to six bits
    for (int len = 1; len <= 6; len++) begin
      for (int p = 0; p < (1 << len); p++) begin
        runStream(16'(p), len, "sweep");
      end
    end
    // long pseudo-random stream without reset
    doReset();
    for (int i = 0; i < 400; i++) step(1'(((i * 7) ^ (i >> 2) ^ (i * 13 >> 3)) & 1), "long");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule